// File: doc/BRIEF.md
# Dual-Channel Phase Comparator with Lock Monitor

This block is the digital heart of a two-channel frequency synthesizer. Each channel receives two single-cycle strobes, one from the divided reference and one from the divided VCO feedback, both already synchronous to the reference-oscillator clock `clk`. A phase-frequency comparator turns the order and spacing of those strobes into a charge-pump command made of two wires.

- `pump_up` asks for the pin to be driven high.
- `pump_dn` asks for it to be driven low.
- Both low means high-impedance.

A per-channel polarity bit swaps the two wires to suit the VCO and loop-filter slope. When a comparison completes, both wires are high for one cycle, so there is no dead zone at zero phase error.

Each channel measures how wide its phase-error pulse is, counted in `clk` cycles. It drops its lock flag on one wide pulse. It raises the flag again only after several consecutive narrow comparisons. A sleep input per channel parks that channel: its pump outputs go quiet and it counts as locked. On leaving sleep, the channel re-arms on the first complete strobe pair before it issues any command.

One output pin either carries the combined lock status of both channels or mirrors one of the four comparison strobes for monitoring.

Top module: `dual_pfd_lock`

## Requirements
- R1: With `pol[i]`=1, a reference strobe arriving before the feedback strobe holds `pump_up[i]` high from the cycle after the reference strobe until the pair clears. A feedback strobe arriving first does the same on `pump_dn[i]`. Encoding: `pump_up` high means drive high, `pump_dn` high means drive low, both low means high-impedance.
- R2: With `pol[i]`=0, the roles of `pump_up[i]` and `pump_dn[i]` in R1 are exchanged.
- R3: When the lagging strobe arrives, both pump outputs are high for exactly one cycle and then both clear. Strobes arriving in the same cycle produce just this one-cycle pulse on both outputs.
- R4: Further strobes on the leading input before the lagging strobe arrives neither extend nor stack the error. A single completion clears the channel.
- R5: When a channel's error pulse reaches UNLOCK_CYC cycles (default 2), its lock flag clears at that clock edge. With `mon_en`=0, `lock_pin` goes low one cycle later. An error pulse of one cycle does not clear the lock flag.
- R6: The lock flag sets after GOOD_RUNS (default 3) consecutive completed comparisons whose error width is at most LOCK_CYC (default 1). A wider comparison restarts the count.
- R7: With `mon_en`=0, `lock_pin` is a registered AND over the channels of "asleep or locked". It is updated one cycle after the channel states.
- R8: While `sleep[i]` is high, both pump outputs of channel i are low from the next cycle and the channel counts as locked for `lock_pin`. Its lock history is cleared, so after waking the channel reports unlocked until it qualifies again.
- R9: After reset or after leaving sleep, the pump outputs stay low until a reference strobe and a feedback strobe have both been seen, in the same cycle or in different cycles. Only strobes after that arming pair are compared.
- R10: With `mon_en`=1, `lock_pin` shows, one cycle delayed, the strobe picked by `mon_sel`: 0 = channel 0 reference, 1 = channel 1 reference, 2 = channel 0 feedback, 3 = channel 1 feedback.
- R11: After reset, all pump outputs and `lock_pin` are low, and every channel is unlocked and unarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_stb | input | NCH | Divided reference strobe per channel |
| fb_stb | input | NCH | Divided feedback strobe per channel |
| pol | input | NCH | Command polarity per channel |
| sleep | input | NCH | Power-save request per channel |
| mon_en | input | 1 | 1 = pin shows a strobe, 0 = pin shows lock status |
| mon_sel | input | $clog2(NCH)+1 | Strobe picked for monitoring |
| pump_up | output | NCH | Drive-high command per channel |
| pump_dn | output | NCH | Drive-low command per channel |
| lock_pin | output | 1 | Combined lock status or monitored strobe |

## Verification
The hardest state to reach is relocking after a disturbance. The bench must bring about a lock loss, then two clean comparisons, then a wide one that restarts qualification, and finally three clean ones. Meanwhile the other channel must stay locked, so that the AND on the pin exposes exactly one channel. The stimulus strings zero-error and multi-cycle lead pairs on chosen channels. It then moves channels into and out of sleep and re-arms them with split reference and feedback strobes. A behavioural model is compared against the design on every cycle throughout.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_WAIT  = 2'd1,
    MODE_RUN   = 2'd2
  } pfd_mode_e;
endpackage

// File: rtl/pfd_channel.sv
// One comparator channel: arming after reset/sleep, phase-frequency
// state and polarity-mapped registered pump commands.
module pfd_channel
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_stb,
  input  logic fb_stb,
  input  logic sleep,
  input  logic pol,
  output logic up_st,
  output logic dn_st,
  output logic asleep,
  output logic pump_up,
  output logic pump_dn
);
  pfd_mode_e mode_q, mode_n;
  logic up_q, dn_q, up_n, dn_n;
  logic sr_q, sf_q, sr_n, sf_n;
  logic seen_r, seen_f, clr;

  always_comb begin
    seen_r = sr_q | ref_stb;
    seen_f = sf_q | fb_stb;
    clr    = up_q & dn_q;
    mode_n = mode_q;
    up_n   = 1'b0;
    dn_n   = 1'b0;
    sr_n   = 1'b0;
    sf_n   = 1'b0;
    if (sleep) begin
      mode_n = MODE_SLEEP;
    end else if (mode_q == MODE_RUN) begin
      // R3/R4: completion clears; leading input saturates while waiting
      up_n = ref_stb | (up_q & ~clr);
      dn_n = fb_stb  | (dn_q & ~clr);
    end else if (seen_r & seen_f) begin
      // R9: arming pair consumed, comparison starts afterwards
      mode_n = MODE_RUN;
    end else begin
      mode_n = MODE_WAIT;
      sr_n   = seen_r;
      sf_n   = seen_f;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_WAIT;
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      sr_q    <= 1'b0;
      sf_q    <= 1'b0;
      pump_up <= 1'b0;
      pump_dn <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      up_q    <= up_n;
      dn_q    <= dn_n;
      sr_q    <= sr_n;
      sf_q    <= sf_n;
      pump_up <= pol ? up_n : dn_n;
      pump_dn <= pol ? dn_n : up_n;
    end
  end

  assign up_st  = up_q;
  assign dn_st  = dn_q;
  assign asleep = (mode_q == MODE_SLEEP);
endmodule

// File: rtl/pfd_lock_qual.sv
// Lock qualification from the width of the phase-error pulse.
module pfd_lock_qual #(
  parameter int UNLOCK_CYC = 2,
  parameter int LOCK_CYC   = 1,
  parameter int GOOD_RUNS  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic up_st,
  input  logic dn_st,
  output logic locked
);
  localparam int ERRW = $clog2(UNLOCK_CYC + 1);
  localparam int GW   = $clog2(GOOD_RUNS + 1);
  localparam logic [ERRW-1:0] ERR_MAX = ERRW'(UNLOCK_CYC);
  localparam logic [ERRW-1:0] ERR_OK  = ERRW'(LOCK_CYC);
  localparam logic [GW-1:0]   RUN_MAX = GW'(GOOD_RUNS);

  logic [ERRW-1:0] err_q, err_n;
  logic [GW-1:0]   good_q, good_n;
  logic            lock_n, err_act, done;

  always_comb begin
    err_act = up_st ^ dn_st;
    done    = up_st & dn_st;
    err_n   = '0;
    good_n  = good_q;
    lock_n  = locked;
    if (clear) begin
      good_n = '0;
      lock_n = 1'b0;
    end else if (err_act) begin
      err_n = (err_q == ERR_MAX) ? err_q : err_q + ERRW'(1);
      if (err_n >= ERR_MAX) begin
        lock_n = 1'b0;
        good_n = '0;
      end
    end else if (done) begin
      if (err_q <= ERR_OK) begin
        good_n = (good_q == RUN_MAX) ? good_q : good_q + GW'(1);
        if (good_n == RUN_MAX) lock_n = 1'b1;
      end else begin
        good_n = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= '0;
      good_q <= '0;
      locked <= 1'b0;
    end else begin
      err_q  <= err_n;
      good_q <= good_n;
      locked <= lock_n;
    end
  end
endmodule

// File: rtl/pfd_pin_sel.sv
// Shared output pin: combined lock status or one monitored strobe.
module pfd_pin_sel #(
  parameter int NCH = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      mon_en,
  input  logic [$clog2(NCH):0]      mon_sel,
  input  logic [NCH-1:0]            ref_stb,
  input  logic [NCH-1:0]            fb_stb,
  input  logic [NCH-1:0]            asleep,
  input  logic [NCH-1:0]            locked,
  output logic                      lock_pin
);
  localparam int CHW  = $clog2(NCH);
  localparam int SELW = CHW + 1;

  logic pick, all_ok;

  always_comb begin
    pick   = mon_sel[SELW-1] ? fb_stb[mon_sel[CHW-1:0]] : ref_stb[mon_sel[CHW-1:0]];
    all_ok = &(asleep | locked);
  end

  always_ff @(posedge clk) begin
    if (rst) lock_pin <= 1'b0;
    else     lock_pin <= mon_en ? pick : all_ok;
  end
endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock #(
  parameter int NCH        = 2,
  parameter int UNLOCK_CYC = 2,
  parameter int LOCK_CYC   = 1,
  parameter int GOOD_RUNS  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        ref_stb,
  input  logic [NCH-1:0]        fb_stb,
  input  logic [NCH-1:0]        pol,
  input  logic [NCH-1:0]        sleep,
  input  logic                  mon_en,
  input  logic [$clog2(NCH):0]  mon_sel,
  output logic [NCH-1:0]        pump_up,
  output logic [NCH-1:0]        pump_dn,
  output logic                  lock_pin
);
  logic [NCH-1:0] up_st, dn_st, asleep, locked;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pfd_channel u_cmp (
      .clk     (clk),
      .rst     (rst),
      .ref_stb (ref_stb[i]),
      .fb_stb  (fb_stb[i]),
      .sleep   (sleep[i]),
      .pol     (pol[i]),
      .up_st   (up_st[i]),
      .dn_st   (dn_st[i]),
      .asleep  (asleep[i]),
      .pump_up (pump_up[i]),
      .pump_dn (pump_dn[i])
    );

    pfd_lock_qual #(
      .UNLOCK_CYC (UNLOCK_CYC),
      .LOCK_CYC   (LOCK_CYC),
      .GOOD_RUNS  (GOOD_RUNS)
    ) u_lq (
      .clk    (clk),
      .rst    (rst),
      .clear  (sleep[i]),
      .up_st  (up_st[i]),
      .dn_st  (dn_st[i]),
      .locked (locked[i])
    );
  end

  pfd_pin_sel #(.NCH(NCH)) u_pin (
    .clk      (clk),
    .rst      (rst),
    .mon_en   (mon_en),
    .mon_sel  (mon_sel),
    .ref_stb  (ref_stb),
    .fb_stb   (fb_stb),
    .asleep   (asleep),
    .locked   (locked),
    .lock_pin (lock_pin)
  );
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
  parameter int NCH        = 2,
  parameter int UNLOCK_CYC = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NCH-1:0]       ref_stb,
  input logic [NCH-1:0]       fb_stb,
  input logic [NCH-1:0]       sleep,
  input logic                 mon_en,
  input logic [$clog2(NCH):0] mon_sel,
  input logic [NCH-1:0]       pump_up,
  input logic [NCH-1:0]       pump_dn,
  input logic                 lock_pin
);
  localparam int CHW  = $clog2(NCH);
  localparam int SELW = CHW + 1;
  localparam int ERRW = $clog2(UNLOCK_CYC + 1);
  localparam logic [ERRW-1:0] RMAX = ERRW'(UNLOCK_CYC);
  localparam logic [ERRW-1:0] RHIT = ERRW'(UNLOCK_CYC - 1);

  logic alive, sel_stb;

  always_ff @(posedge clk) begin
    if (rst) alive <= 1'b0;
    else     alive <= 1'b1;
  end

  always_comb
    sel_stb = mon_sel[SELW-1] ? fb_stb[mon_sel[CHW-1:0]] : ref_stb[mon_sel[CHW-1:0]];

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    logic [ERRW-1:0] run;
    logic            hit;

    always_ff @(posedge clk) begin
      if (rst || sleep[i]) begin
        run <= '0;
        hit <= 1'b0;
      end else begin
        run <= (pump_up[i] ^ pump_dn[i]) ? ((run == RMAX) ? run : run + ERRW'(1)) : '0;
        hit <= (pump_up[i] ^ pump_dn[i]) && (run >= RHIT);
      end
    end

    // R3
    a_r3_single_overlap: assert property (@(posedge clk) disable iff (rst)
      (pump_up[i] && pump_dn[i] && !(ref_stb[i] && fb_stb[i])) |=> !(pump_up[i] && pump_dn[i]));

    // R8
    a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
      sleep[i] |=> (!pump_up[i] && !pump_dn[i]));

    // R5
    a_r5_unlock_drop: assert property (@(posedge clk) disable iff (rst)
      (hit && !mon_en) |=> !lock_pin);
  end

  // R7
  a_r7_sleep_counts_locked: assert property (@(posedge clk) disable iff (rst)
    (alive && !mon_en && $past(&sleep)) |=> lock_pin);

  // R10
  a_r10_monitor_follow: assert property (@(posedge clk) disable iff (rst)
    mon_en |=> (lock_pin == $past(sel_stb)));
endmodule

bind dual_pfd_lock pfd_checker #(.NCH(NCH), .UNLOCK_CYC(UNLOCK_CYC)) u_pfd_chk (
  .clk      (clk),
  .rst      (rst),
  .ref_stb  (ref_stb),
  .fb_stb   (fb_stb),
  .sleep    (sleep),
  .mon_en   (mon_en),
  .mon_sel  (mon_sel),
  .pump_up  (pump_up),
  .pump_dn  (pump_dn),
  .lock_pin (lock_pin)
);

// File: tb/sim_dual_pfd_lock.sv
module sim_dual_pfd_lock;
  localparam int UNL = 2;
  localparam int LCK = 1;
  localparam int RUNS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] ref_stb = '0, fb_stb = '0, pol = 2'b11, sleep = '0;
  logic mon_en = 1'b0;
  logic [1:0] mon_sel = '0;
  logic [1:0] pump_up, pump_dn;
  logic lock_pin;

  int checks = 0, errors = 0;
  bit started = 0;
  string cur_req = "R11";

  always #5 clk = ~clk;

  dual_pfd_lock u0 (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .fb_stb(fb_stb), .pol(pol),
    .sleep(sleep), .mon_en(mon_en), .mon_sel(mon_sel),
    .pump_up(pump_up), .pump_dn(pump_dn), .lock_pin(lock_pin)
  );

  // behavioural reference model: md 0 sleep, 1 waiting for arming pair, 2 running
  int md[2], up[2], dn[2], sr[2], sf[2], er[2], gd[2], lk[2];
  bit [1:0] e_up, e_dn;
  bit e_pin;

  always @(posedge clk) begin
    int pin_n;
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        md[c] = 1; up[c] = 0; dn[c] = 0; sr[c] = 0; sf[c] = 0;
        er[c] = 0; gd[c] = 0; lk[c] = 0;
      end
      e_up = '0; e_dn = '0; e_pin = 0;
    end else begin
      if (mon_en) pin_n = mon_sel[1] ? fb_stb[mon_sel[0]] : ref_stb[mon_sel[0]];
      else pin_n = ((md[0] == 0 || lk[0] != 0) && (md[1] == 0 || lk[1] != 0)) ? 1 : 0;
      for (int c = 0; c < 2; c++) begin
        if (sleep[c]) begin
          er[c] = 0; gd[c] = 0; lk[c] = 0;
          md[c] = 0; up[c] = 0; dn[c] = 0; sr[c] = 0; sf[c] = 0;
        end else begin
          if (up[c] != dn[c]) begin
            er[c] = (er[c] + 1 > UNL) ? UNL : er[c] + 1;
            if (er[c] >= UNL) begin lk[c] = 0; gd[c] = 0; end
          end else begin
            if (up[c] != 0 && dn[c] != 0) begin
              if (er[c] <= LCK) begin
                gd[c] = (gd[c] + 1 > RUNS) ? RUNS : gd[c] + 1;
                if (gd[c] >= RUNS) lk[c] = 1;
              end else gd[c] = 0;
            end
            er[c] = 0;
          end
          if (md[c] != 2) begin
            if (ref_stb[c]) sr[c] = 1;
            if (fb_stb[c]) sf[c] = 1;
            up[c] = 0; dn[c] = 0;
            if (sr[c] != 0 && sf[c] != 0) begin md[c] = 2; sr[c] = 0; sf[c] = 0; end
            else md[c] = 1;
          end else begin
            int cl;
            cl = (up[c] != 0 && dn[c] != 0) ? 1 : 0;
            up[c] = (ref_stb[c] || (up[c] != 0 && cl == 0)) ? 1 : 0;
            dn[c] = (fb_stb[c] || (dn[c] != 0 && cl == 0)) ? 1 : 0;
          end
        end
        e_up[c] = pol[c] ? up[c][0] : dn[c][0];
        e_dn[c] = pol[c] ? dn[c][0] : up[c][0];
      end
      e_pin = pin_n[0];
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (pump_up !== e_up || pump_dn !== e_dn || lock_pin !== e_pin) begin
        errors++;
        $display("FAIL %s per-cycle: actual up=%b dn=%b pin=%b expected up=%b dn=%b pin=%b",
                 cur_req, pump_up, pump_dn, lock_pin, e_up, e_dn, e_pin);
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [1:0] r, input logic [1:0] f);
    ref_stb = r; fb_stb = f;
    @(negedge clk);
    ref_stb = '0; fb_stb = '0;
  endtask

  task automatic pairs(input logic [1:0] m, input int n);
    repeat (n) begin pulse(m, m); idle(5); end
  endtask

  task automatic lead(input logic [1:0] m, input int k);
    pulse(m, 2'b00); idle(k - 1); pulse(2'b00, m); idle(5);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0; started = 1;
    cur_req = "R11";
    chk("R11", "pumps after reset", {pump_up | pump_dn}, 2'b00);
    chk("R11", "pin after reset", {1'b0, lock_pin}, 2'b00);

    cur_req = "R9";
    pulse(2'b11, 2'b11);
    chk("R9", "arming pair gives no command", pump_up | pump_dn, 2'b00);
    idle(3);

    cur_req = "R3";
    pulse(2'b11, 2'b11);
    chk("R3", "zero error up", pump_up, 2'b11);
    chk("R3", "zero error dn", pump_dn, 2'b11);
    idle(1);
    chk("R3", "cleared after one cycle", pump_up | pump_dn, 2'b00);
    idle(4);
    cur_req = "R6";
    pairs(2'b11, 1);
    chk("R6", "two good comparisons", {1'b0, lock_pin}, 2'b00);
    pairs(2'b11, 1);
    chk("R6", "three good comparisons", {1'b0, lock_pin}, 2'b01);

    cur_req = "R1";
    pulse(2'b01, 2'b00);
    chk("R1", "reference leads up", pump_up, 2'b01);
    chk("R1", "reference leads dn", pump_dn, 2'b00);
    pulse(2'b00, 2'b01);
    chk("R1", "completion overlap", {pump_up[0], pump_dn[0]}, 2'b11);
    idle(5);
    pulse(2'b00, 2'b01);
    chk("R1", "feedback leads dn", pump_dn, 2'b01);
    chk("R1", "feedback leads up", pump_up, 2'b00);
    pulse(2'b01, 2'b00); idle(5);
    chk("R5", "one-cycle error keeps lock", {1'b0, lock_pin}, 2'b01);

    cur_req = "R2";
    pol = 2'b01;
    pulse(2'b10, 2'b00);
    chk("R2", "inverted reference leads dn", pump_dn, 2'b10);
    chk("R2", "inverted reference leads up", pump_up, 2'b00);
    pulse(2'b00, 2'b10); idle(5);

    cur_req = "R5";
    pulse(2'b01, 2'b00); idle(2);
    chk("R1", "wide lead holds up", pump_up, 2'b01);
    pulse(2'b00, 2'b01); idle(5);
    chk("R5", "three-cycle error unlocks", {1'b0, lock_pin}, 2'b00);

    cur_req = "R6";
    pairs(2'b11, 2);
    chk("R6", "not yet relocked", {1'b0, lock_pin}, 2'b00);
    lead(2'b01, 3);
    pairs(2'b11, 2);
    chk("R6", "count restarted by wide comparison", {1'b0, lock_pin}, 2'b00);
    pairs(2'b11, 1);
    chk("R6", "relocked", {1'b0, lock_pin}, 2'b01);

    cur_req = "R4";
    pulse(2'b01, 2'b00); idle(1);
    pulse(2'b01, 2'b00);
    chk("R4", "repeated reference keeps up", pump_up, 2'b01);
    chk("R4", "repeated reference no dn", pump_dn, 2'b00);
    idle(1);
    pulse(2'b00, 2'b01);
    chk("R4", "single completion", {pump_up[0], pump_dn[0]}, 2'b11);
    idle(1);
    chk("R4", "no stacked error", pump_up | pump_dn, 2'b00);
    idle(4);

    cur_req = "R8";
    sleep = 2'b10; idle(3);
    chk("R7", "awake unlocked channel forces low", {1'b0, lock_pin}, 2'b00);
    pulse(2'b10, 2'b00);
    chk("R8", "sleeping channel quiet", {pump_up[1], pump_dn[1]}, 2'b00);
    idle(3);
    cur_req = "R7";
    pairs(2'b01, 3);
    chk("R7", "locked plus asleep", {1'b0, lock_pin}, 2'b01);
    sleep = 2'b11; idle(3);
    pulse(2'b01, 2'b00); idle(2); pulse(2'b00, 2'b01); idle(4);
    chk("R8", "both asleep report locked", {1'b0, lock_pin}, 2'b01);
    chk("R8", "both asleep quiet", pump_up | pump_dn, 2'b00);

    cur_req = "R9";
    sleep = 2'b00; idle(3);
    chk("R7", "woken channels unlocked", {1'b0, lock_pin}, 2'b00);
    pulse(2'b11, 2'b00);
    chk("R9", "reference alone does not arm", pump_up | pump_dn, 2'b00);
    idle(1);
    pulse(2'b00, 2'b11);
    chk("R9", "arming feedback gives no command", pump_up | pump_dn, 2'b00);
    pulse(2'b01, 2'b00);
    chk("R9", "armed channel compares", pump_up, 2'b01);
    pulse(2'b00, 2'b01); idle(3);

    cur_req = "R10";
    mon_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      logic [1:0] m;
      m = (s[0]) ? 2'b10 : 2'b01;
      mon_sel = s[1:0];
      idle(1);
      if (s[1]) pulse(2'b00, m); else pulse(m, 2'b00);
      chk("R10", "selected strobe shown", {1'b0, lock_pin}, 2'b01);
      if (s[1]) pulse(m, 2'b00); else pulse(2'b00, m);
      chk("R10", "other strobe not shown", {1'b0, lock_pin}, 2'b00);
      idle(2);
    end
    mon_en = 1'b0;
    idle(3);
    finish_run();
  end
endmodule